// File: doc/BRIEF.md
# 1-Wire Slave ROM-Phase Selector

This block sits on the device side of a 1-Wire bus, above a slot layer that has already turned line waveforms into clean single-cycle events: a bus reset, a received bit (with its value), and a request for the bit to drive in a read slot. From these events it decides whether the device stays in the conversation during the ROM-level command phase. It holds a fixed identifier, set by parameter, and answers three commands: a plain select, a select that also moves the device to overdrive speed, and the tree-walk search that lets a master find every identifier on the bus.

After each bus reset the block first collects a command byte, least significant bit first. Under either select command it compares each following bit with its own identifier, lowest bit first, and drops out at the first difference. Under search it answers each identifier position with two read slots, the true bit and then its inverse, then takes the master's chosen direction and stays only if it equals its own bit. Once dropped, the device releases the line and ignores all traffic until the next reset. A device that survives all identifier bits raises its selected flag and hands control to the transport layer.

Top module: `owrs_rom_select`

## Requirements
- R1: After the reset input or a bus-reset event, `engaged` is 1, `selected` is 0, `overdrive` is 0 and `tx_bit` is 1 from the next cycle on.
- R2: The command byte is taken from the first 8 received bits after reset, first bit into bit 0; the byte 0x55 starts an identifier compare at standard speed.
- R3: Under compare, received bits are matched with identifier bits 0 up to ID_BITS-1 in that order; if all match, `selected` becomes 1 on the cycle after the last bit, with `overdrive` 0.
- R4: Under compare, the first received bit that differs from the local bit drives `engaged` to 0 on the next cycle; all later bits, read requests and command bytes have no effect until a bus reset.
- R5: The byte 0x69 behaves as 0x55, except that a full match also sets `overdrive` to 1; a failed compare leaves `overdrive` at 0.
- R6: Under search (byte 0xF0), for each position N the first read request sees `tx_bit` equal to identifier bit N and the second sees its inverse.
- R7: Under search, a received direction bit equal to identifier bit N moves on to position N+1; after position ID_BITS-1 is accepted, `selected` is 1 and `overdrive` stays 0.
- R8: Under search, a direction bit that differs from identifier bit N drives `engaged` to 0, after which every read request sees `tx_bit` at 1.
- R9: Any command byte other than 0x55, 0x69 and 0xF0 drives `engaged` to 0 until the next bus reset.
- R10: A bus reset at any point, including in the middle of a compare, a search or the inactive state, restarts command capture from bit 0 and position 0.
- R11: `tx_bit` is 1 whenever the block is not in a search answer slot; read requests during command capture, compare or after selection change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | One-cycle pulse: slot layer saw a bus reset |
| rx_valid | input | 1 | One-cycle pulse: a write slot delivered a bit |
| rx_bit | input | 1 | Value of the received bit, valid with `rx_valid` |
| tx_req | input | 1 | One-cycle pulse: a read slot consumes `tx_bit` |
| tx_bit | output | 1 | Bit to drive in the current read slot, 1 means released |
| engaged | output | 1 | Device still takes part in the ROM phase |
| selected | output | 1 | All identifier bits matched; transport phase may begin |
| overdrive | output | 1 | Speed flag, 1 after a successful overdrive select |

## Verification
The bench builds the block with its default 64-bit identifier, an asymmetric constant so that every position differs from its neighbours in some test, and the indexed bit-selection variant. That width lets mismatches be placed at the first and the last identifier position and a search be walked over its full length, so the end-of-identifier handoff to the selected state is reached by both compare and search. Resets are thrown into the middle of a compare and into the dropped-out state to reach the restart paths.

// File: rtl/owrs_pkg.sv
package owrs_pkg;

   typedef enum logic [2:0] {
      ST_CAPTURE  = 3'd0,
      ST_MATCH    = 3'd1,
      ST_SEARCH   = 3'd2,
      ST_SELECTED = 3'd3,
      ST_DROPPED  = 3'd4
   } rom_state_t;

   typedef enum logic [1:0] {
      PH_TRUE = 2'd0,
      PH_INV  = 2'd1,
      PH_DIR  = 2'd2
   } search_phase_t;

endpackage

// File: rtl/owrs_cmd_shift.sv
module owrs_cmd_shift #(
   parameter int CMD_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             enable,
   input  logic             bit_in,
   output logic             byte_done,
   output logic [CMD_W-1:0] byte_val
);
   localparam int CW = (CMD_W > 1) ? $clog2(CMD_W) : 1;
   localparam logic [CW-1:0] LAST_CNT = CW'(CMD_W - 1);

   logic [CMD_W-1:0] sr_q;
   logic [CW-1:0]    cnt_q;

   assign byte_done = enable && (cnt_q == LAST_CNT);
   assign byte_val  = {bit_in, sr_q[CMD_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q  <= '0;
         cnt_q <= '0;
      end else if (clear) begin
         sr_q  <= '0;
         cnt_q <= '0;
      end else if (enable) begin
         sr_q  <= {bit_in, sr_q[CMD_W-1:1]};
         cnt_q <= byte_done ? '0 : cnt_q + 1'b1;
      end
   end

   AST_CMD_COUNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt_q == '0)); // R10

endmodule

// File: rtl/owrs_id_cursor.sv
module owrs_id_cursor #(
   parameter int                   ID_BITS  = 64,
   parameter logic [ID_BITS-1:0]   ROM_ID   = '0,
   parameter bit                   SHIFT_ID = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic advance,
   output logic id_bit,
   output logic id_last
);
   localparam int IW = $clog2(ID_BITS);
   localparam logic [IW-1:0] LAST_IDX = IW'(ID_BITS - 1);

   logic [IW-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       idx_q <= '0;
      else if (clear)   idx_q <= '0;
      else if (advance) idx_q <= idx_q + 1'b1;
   end

   assign id_last = (idx_q == LAST_IDX);

   generate
      if (SHIFT_ID) begin : g_rotate
         logic [ID_BITS-1:0] rot_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       rot_q <= ROM_ID;
            else if (clear)   rot_q <= ROM_ID;
            else if (advance) rot_q <= {rot_q[0], rot_q[ID_BITS-1:1]};
         end
         assign id_bit = rot_q[0];
      end else begin : g_index
         assign id_bit = ROM_ID[idx_q];
      end
   endgenerate

   AST_CURSOR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !clear) |=> (idx_q == $past(idx_q) + 1'b1)); // R3
   AST_CURSOR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(advance && id_last)); // R7

endmodule

// File: rtl/owrs_sel_fsm.sv
module owrs_sel_fsm
   import owrs_pkg::*;
#(
   parameter int               CMD_W         = 8,
   parameter logic [CMD_W-1:0] CMD_SELECT    = 8'h55,
   parameter logic [CMD_W-1:0] CMD_SELECT_OD = 8'h69,
   parameter logic [CMD_W-1:0] CMD_SEARCH    = 8'hF0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_rst,
   input  logic             rx_valid,
   input  logic             rx_bit,
   input  logic             tx_req,
   input  logic             cmd_done,
   input  logic [CMD_W-1:0] cmd_val,
   input  logic             id_bit,
   input  logic             id_last,
   output logic             cap_en,
   output logic             cur_adv,
   output logic             tx_bit,
   output logic             engaged,
   output logic             selected,
   output logic             overdrive
);
   rom_state_t    st_q, st_n;
   search_phase_t ph_q, ph_n;
   logic          odp_q, odp_n;
   logic          odo_q, odo_n;

   assign cap_en = (st_q == ST_CAPTURE) && rx_valid && !bus_rst;

   always_comb begin
      st_n    = st_q;
      ph_n    = ph_q;
      odp_n   = odp_q;
      odo_n   = odo_q;
      cur_adv = 1'b0;
      if (bus_rst) begin
         st_n  = ST_CAPTURE;
         ph_n  = PH_TRUE;
         odp_n = 1'b0;
         odo_n = 1'b0;
      end else begin
         case (st_q)
            ST_CAPTURE: begin
               if (cmd_done) begin
                  if (cmd_val == CMD_SELECT) begin
                     st_n = ST_MATCH;
                  end else if (cmd_val == CMD_SELECT_OD) begin
                     st_n  = ST_MATCH;
                     odp_n = 1'b1;
                  end else if (cmd_val == CMD_SEARCH) begin
                     st_n = ST_SEARCH;
                     ph_n = PH_TRUE;
                  end else begin
                     st_n = ST_DROPPED;
                  end
               end
            end
            ST_MATCH: begin
               if (rx_valid) begin
                  if (rx_bit != id_bit) begin
                     st_n = ST_DROPPED;
                  end else if (id_last) begin
                     st_n  = ST_SELECTED;
                     odo_n = odp_q;
                  end else begin
                     cur_adv = 1'b1;
                  end
               end
            end
            ST_SEARCH: begin
               case (ph_q)
                  PH_TRUE: if (tx_req) ph_n = PH_INV;
                  PH_INV:  if (tx_req) ph_n = PH_DIR;
                  PH_DIR: begin
                     if (rx_valid) begin
                        if (rx_bit != id_bit) begin
                           st_n = ST_DROPPED;
                        end else begin
                           ph_n = PH_TRUE;
                           if (id_last) st_n = ST_SELECTED;
                           else         cur_adv = 1'b1;
                        end
                     end
                  end
                  default: ph_n = PH_TRUE;
               endcase
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_CAPTURE;
         ph_q  <= PH_TRUE;
         odp_q <= 1'b0;
         odo_q <= 1'b0;
      end else begin
         st_q  <= st_n;
         ph_q  <= ph_n;
         odp_q <= odp_n;
         odo_q <= odo_n;
      end
   end

   always_comb begin
      tx_bit = 1'b1;
      if (st_q == ST_SEARCH) begin
         if (ph_q == PH_TRUE)     tx_bit = id_bit;
         else if (ph_q == PH_INV) tx_bit = ~id_bit;
      end
   end

   assign engaged   = (st_q != ST_DROPPED);
   assign selected  = (st_q == ST_SELECTED);
   assign overdrive = odo_q;

   AST_BUS_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst |=> (engaged && !selected && !overdrive && tx_bit)); // R1
   AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (!engaged && !bus_rst) |=> !engaged); // R4
   AST_OD_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      overdrive |-> selected); // R5
   AST_DROPPED_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      !engaged |-> tx_bit); // R8
   AST_SELECTED_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      selected |-> tx_bit); // R11
   AST_SELECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (selected && !bus_rst) |=> (selected && $stable(overdrive))); // R3

endmodule

// File: rtl/owrs_rom_select.sv
module owrs_rom_select #(
   parameter int                 ID_BITS       = 64,
   parameter logic [ID_BITS-1:0] ROM_ID        = 64'h8D3A_F061_52C9_E7B4,
   parameter int                 CMD_W         = 8,
   parameter logic [CMD_W-1:0]   CMD_SELECT    = 8'h55,
   parameter logic [CMD_W-1:0]   CMD_SELECT_OD = 8'h69,
   parameter logic [CMD_W-1:0]   CMD_SEARCH    = 8'hF0,
   parameter bit                 SHIFT_ID      = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_rst,
   input  logic rx_valid,
   input  logic rx_bit,
   input  logic tx_req,
   output logic tx_bit,
   output logic engaged,
   output logic selected,
   output logic overdrive
);
   generate
      if (ID_BITS < 2) begin : g_chk_id
         $error("owrs_rom_select: ID_BITS must be at least 2");
      end
      if (CMD_W < 2) begin : g_chk_cmd
         $error("owrs_rom_select: CMD_W must be at least 2");
      end
      if (CMD_SELECT == CMD_SELECT_OD || CMD_SELECT == CMD_SEARCH
          || CMD_SELECT_OD == CMD_SEARCH) begin : g_chk_codes
         $error("owrs_rom_select: command codes must be distinct");
      end
   endgenerate

   logic             cap_en;
   logic             cmd_done;
   logic [CMD_W-1:0] cmd_val;
   logic             cur_adv;
   logic             id_bit;
   logic             id_last;

   owrs_cmd_shift #(.CMD_W(CMD_W)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (bus_rst),
      .enable    (cap_en),
      .bit_in    (rx_bit),
      .byte_done (cmd_done),
      .byte_val  (cmd_val)
   );

   owrs_id_cursor #(
      .ID_BITS  (ID_BITS),
      .ROM_ID   (ROM_ID),
      .SHIFT_ID (SHIFT_ID)
   ) u_cursor (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (bus_rst),
      .advance (cur_adv),
      .id_bit  (id_bit),
      .id_last (id_last)
   );

   owrs_sel_fsm #(
      .CMD_W         (CMD_W),
      .CMD_SELECT    (CMD_SELECT),
      .CMD_SELECT_OD (CMD_SELECT_OD),
      .CMD_SEARCH    (CMD_SEARCH)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_rst   (bus_rst),
      .rx_valid  (rx_valid),
      .rx_bit    (rx_bit),
      .tx_req    (tx_req),
      .cmd_done  (cmd_done),
      .cmd_val   (cmd_val),
      .id_bit    (id_bit),
      .id_last   (id_last),
      .cap_en    (cap_en),
      .cur_adv   (cur_adv),
      .tx_bit    (tx_bit),
      .engaged   (engaged),
      .selected  (selected),
      .overdrive (overdrive)
   );

endmodule

// File: tb/owrs_rom_select_tb.sv
module owrs_rom_select_tb;
   localparam int          CLK_PERIOD = 10;
   localparam int          NB         = 64;
   localparam logic [63:0] ID         = 64'h8D3A_F061_52C9_E7B4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_rst = 1'b0;
   logic rx_valid = 1'b0;
   logic rx_bit = 1'b0;
   logic tx_req = 1'b0;
   logic tx_bit, engaged, selected, overdrive;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   owrs_rom_select #(.ID_BITS(NB), .ROM_ID(ID)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rx_valid(rx_valid),
      .rx_bit(rx_bit), .tx_req(tx_req), .tx_bit(tx_bit), .engaged(engaged),
      .selected(selected), .overdrive(overdrive)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic pulse_reset();
      @(negedge clk); bus_rst = 1'b1;
      @(negedge clk); bus_rst = 1'b0;
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk); rx_valid = 1'b1; rx_bit = b;
      @(negedge clk); rx_valid = 1'b0; rx_bit = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) send_bit(v[i]);
   endtask

   task automatic read_slot(output logic b);
      @(negedge clk); b = tx_bit; tx_req = 1'b1;
      @(negedge clk); tx_req = 1'b0;
   endtask

   task automatic check_idle(input string req);
      chk({req, " engaged"}, engaged, 1'b1);
      chk({req, " selected"}, selected, 1'b0);
      chk({req, " overdrive"}, overdrive, 1'b0);
      chk({req, " tx_bit"}, tx_bit, 1'b1);
   endtask

   task automatic t_reset_state();
      check_idle("R1 por");
      pulse_reset();
      check_idle("R1 busrst");
   endtask

   task automatic t_match(input logic [7:0] cmd, input logic od);
      logic b;
      pulse_reset();
      send_byte(cmd);
      for (int i = 0; i < NB; i++) begin
         send_bit(ID[i]);
         if (i < NB-1) chk("R3 not yet selected", selected, 1'b0);
      end
      chk("R2/R3 selected", selected, 1'b1);
      chk("R5 overdrive flag", overdrive, od);
      read_slot(b);
      chk("R11 tx released after select", b, 1'b1);
      chk("R11 still selected", selected, 1'b1);
   endtask

   task automatic t_match_miss(input logic [7:0] cmd, input int pos);
      logic b;
      pulse_reset();
      send_byte(cmd);
      for (int i = 0; i < NB; i++) begin
         send_bit(i == pos ? ~ID[i] : ID[i]);
         if (i == pos) chk("R4 drop on mismatch", engaged, 1'b0);
      end
      chk("R4 not selected", selected, 1'b0);
      chk("R5 no overdrive", overdrive, 1'b0);
      send_byte(8'hF0);
      read_slot(b);
      chk("R4 ignores later command", b, 1'b1);
      chk("R4 stays dropped", engaged, 1'b0);
   endtask

   task automatic t_search_full();
      logic a, c;
      pulse_reset();
      send_byte(8'hF0);
      for (int i = 0; i < NB; i++) begin
         read_slot(a);
         read_slot(c);
         chk("R6 true bit", a, ID[i]);
         chk("R6 inverted bit", c, ~ID[i]);
         send_bit(ID[i]);
         chk("R7 engaged", engaged, 1'b1);
      end
      chk("R7 selected", selected, 1'b1);
      chk("R7 no overdrive", overdrive, 1'b0);
   endtask

   task automatic t_search_drop(input int pos);
      logic a, c;
      pulse_reset();
      send_byte(8'hF0);
      for (int i = 0; i < pos; i++) begin
         read_slot(a); read_slot(c); send_bit(ID[i]);
      end
      read_slot(a); read_slot(c);
      chk("R6 true bit at drop pos", a, ID[pos]);
      send_bit(~ID[pos]);
      chk("R8 dropped", engaged, 1'b0);
      read_slot(a); read_slot(c);
      chk("R8 released slot 1", a, 1'b1);
      chk("R8 released slot 2", c, 1'b1);
      chk("R8 not selected", selected, 1'b0);
   endtask

   task automatic t_bad_cmd(input logic [7:0] cmd);
      pulse_reset();
      send_byte(cmd);
      chk("R9 unknown command drops", engaged, 1'b0);
      send_byte(8'h55);
      for (int i = 0; i < NB; i++) send_bit(ID[i]);
      chk("R9 stays unselected", selected, 1'b0);
   endtask

   task automatic t_mid_reset();
      logic a, c;
      pulse_reset();
      send_byte(8'h69);
      for (int i = 0; i < 30; i++) send_bit(ID[i]);
      pulse_reset();
      check_idle("R10 after mid-compare reset");
      send_byte(8'hF0);
      read_slot(a); read_slot(c);
      chk("R10 search restarts at bit 0", a, ID[0]);
      chk("R10 inverse at bit 0", c, ~ID[0]);
      pulse_reset();
      send_byte(8'h00);
      chk("R10 dropped before reset", engaged, 1'b0);
      pulse_reset();
      check_idle("R10 after reset from dropped");
      t_match(8'h55, 1'b0);
      pulse_reset();
      chk("R1 reset clears selected", selected, 1'b0);
   endtask

   task automatic t_ignore_reads();
      logic b;
      pulse_reset();
      for (int i = 0; i < 4; i++) send_bit(1'(8'h55 >> i));
      read_slot(b);
      chk("R11 released in capture", b, 1'b1);
      for (int i = 4; i < 8; i++) send_bit(1'(8'h55 >> i));
      for (int i = 0; i < 10; i++) send_bit(ID[i]);
      read_slot(b);
      chk("R11 released in compare", b, 1'b1);
      for (int i = 10; i < NB; i++) send_bit(ID[i]);
      chk("R11 compare unaffected by reads", selected, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_match(8'h55, 1'b0);
      t_match(8'h69, 1'b1);
      t_match_miss(8'h55, 0);
      t_match_miss(8'h55, NB-1);
      t_match_miss(8'h69, 20);
      t_search_full();
      t_search_drop(0);
      t_search_drop(37);
      t_search_drop(NB-1);
      t_bad_cmd(8'hCC);
      t_bad_cmd(8'h33);
      t_mid_reset();
      t_ignore_reads();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

endmodule